// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This block holds the program counter of a small processor and decides its next value on every step. The value depends on a control operation and on the zero and negative status of the most recent result. The supported operations are: advance to the next instruction, jump, three conditional branches, an unconditional skip, a skip taken on zero, a subroutine call and a return. Each instruction occupies one address, so an advance adds 1 and a skip adds 2.

Return addresses live in a stack kept in memory. The stack grows toward address zero, and the stack pointer always addresses the occupied top entry. The block reaches that memory through a simple synchronous port. A write takes effect at the clock edge. A read returns its data one edge after the read enable. Calls and returns therefore take two cycles. During the second cycle a busy flag is high and the operation inputs are ignored. A return with an empty stack is refused and reported on an error output.

Top module: `pc_sequencer`

## Requirements
- R1: While the synchronous reset is high, and directly after it, the program counter equals START_ADDR and the stack pointer equals STACK_TOP. Busy and the underflow flag are low.
- R2: Op code 0 (advance) adds 1 to the program counter. Any unused code (9 to 15) does the same.
- R3: Op code 1 (jump) loads the target address into the program counter.
- R4: Op code 2 branches to the target when zeroFlag is 1. Otherwise the program counter advances by 1.
- R5: Op code 3 branches when the last result was positive, meaning zeroFlag and negFlag are both 0. Op code 4 branches when negFlag is 1. When the condition fails, each of them advances the program counter by 1.
- R6: Op code 5 adds 2 to the program counter. Op code 6 adds 2 when zeroFlag is 1 and adds 1 otherwise.
- R7: Op code 7 (call) proceeds as follows. On the first edge the stack pointer drops by 1 and busy rises. In the busy cycle the block writes the call's address plus 1 to the memory at the new stack pointer. On the second edge the program counter takes the target and busy falls.
- R8: Op code 8 (return), with a non-empty stack, proceeds as follows. The block reads the memory at the stack pointer and busy rises. On the second edge the program counter takes the read word, the stack pointer rises by 1, and busy falls.
- R9: The operation, target and flag inputs presented during a busy cycle have no effect.
- R10: A return issued while the stack pointer equals STACK_TOP raises stackUnderflow for one cycle. It leaves the program counter and the stack pointer unchanged and starts no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Control operation code |
| target | input | ADDR_W | Jump, branch or call destination |
| zeroFlag | input | 1 | Most recent result was zero |
| negFlag | input | 1 | Most recent result was negative |
| pc | output | ADDR_W | Program counter |
| sp | output | ADDR_W | Stack pointer (occupied top entry) |
| busy | output | 1 | Second cycle of a call or return |
| stackUnderflow | output | 1 | Return refused on an empty stack |
| memAddr | output | ADDR_W | Stack memory address |
| memWrEn | output | 1 | Stack memory write enable |
| memWrData | output | ADDR_W | Return address being pushed |
| memRdEn | output | 1 | Stack memory read enable |
| memRdData | input | ADDR_W | Word read, valid one edge after memRdEn |

## Verification
The assertions assume that the memory returns, one edge after a read, the word last written at that address. They also assume that calls never nest deep enough to wrap the stack pointer, since overflow is not guarded. The stimulus keeps the nesting depth to a few entries within a small memory model. It presents only a return at the empty stack as the illegal case. Arbitrary operations are driven during busy cycles to show that they are ignored.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [3:0] {
    OP_SEQ  = 4'd0,
    OP_JMP  = 4'd1,
    OP_BZ   = 4'd2,
    OP_BP   = 4'd3,
    OP_BN   = 4'd4,
    OP_SKP  = 4'd5,
    OP_SKZ  = 4'd6,
    OP_CALL = 4'd7,
    OP_RET  = 4'd8
  } seqOp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALL_WR,
    ST_RET_RD
  } seqState_e;

  typedef struct packed {
    logic pcStep1;
    logic pcStep2;
    logic pcTarget;
    logic pcLatched;
    logic pcFromMem;
    logic spDec;
    logic spInc;
    logic latchCall;
    logic memWr;
    logic memRd;
  } seqStrobe_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] op,
  input  logic       zeroFlag,
  input  logic       negFlag,
  input  logic       spAtTop,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       underflow
);

  seqState_e state, stateNext;
  logic      ufNext;
  logic      isPositive;

  assign isPositive = !zeroFlag && !negFlag;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    ufNext    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        case (op)
          OP_JMP:  strobe.pcTarget = 1'b1;
          OP_BZ:   begin strobe.pcTarget = zeroFlag;   strobe.pcStep1 = !zeroFlag;   end
          OP_BP:   begin strobe.pcTarget = isPositive; strobe.pcStep1 = !isPositive; end
          OP_BN:   begin strobe.pcTarget = negFlag;    strobe.pcStep1 = !negFlag;    end
          OP_SKP:  strobe.pcStep2 = 1'b1;
          OP_SKZ:  begin strobe.pcStep2 = zeroFlag;    strobe.pcStep1 = !zeroFlag;   end
          OP_CALL: begin
            strobe.spDec     = 1'b1;
            strobe.latchCall = 1'b1;
            stateNext        = ST_CALL_WR;
          end
          OP_RET: begin
            if (spAtTop) begin
              ufNext = 1'b1;
            end else begin
              strobe.memRd = 1'b1;
              stateNext    = ST_RET_RD;
            end
          end
          default: strobe.pcStep1 = 1'b1;
        endcase
      end
      ST_CALL_WR: begin
        strobe.memWr     = 1'b1;
        strobe.pcLatched = 1'b1;
        stateNext        = ST_IDLE;
      end
      ST_RET_RD: begin
        strobe.pcFromMem = 1'b1;
        strobe.spInc     = 1'b1;
        stateNext        = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      underflow <= 1'b0;
    end else begin
      state     <= stateNext;
      underflow <= ufNext;
    end
  end

  assign busy = (state != ST_IDLE);

  // R7 / R8: a two-cycle operation occupies exactly one busy cycle
  p_busy_single_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  // R10: the error never coincides with an accepted operation in flight
  p_uf_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
    underflow |-> !busy);

endmodule

// File: rtl/pcseq_dp.sv
module pcseq_dp
  import pcseq_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = 16'h0100,
  parameter logic [ADDR_W-1:0] STACK_TOP  = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] memRdData,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic              spAtTop,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWrData
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] callTarget;
  logic [ADDR_W-1:0] retAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= START_ADDR;
    end else if (strobe.pcTarget) begin
      pc <= target;
    end else if (strobe.pcLatched) begin
      pc <= callTarget;
    end else if (strobe.pcFromMem) begin
      pc <= memRdData;
    end else if (strobe.pcStep2) begin
      pc <= pc + TWO;
    end else if (strobe.pcStep1) begin
      pc <= pc + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= STACK_TOP;
    end else if (strobe.spDec) begin
      sp <= sp - ONE;
    end else if (strobe.spInc) begin
      sp <= sp + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      callTarget <= '0;
      retAddr    <= '0;
    end else if (strobe.latchCall) begin
      callTarget <= target;
      retAddr    <= pc + ONE;
    end
  end

  assign spAtTop   = (sp == STACK_TOP);
  assign memAddr   = sp;
  assign memWrData = retAddr;

  // R7 / R8: the stack pointer only moves one entry at a time
  p_sp_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp) |-> (sp == $past(sp) + ONE) || (sp == $past(sp) - ONE));

  // R8: a completed return lands on the word delivered by memory
  p_pc_from_mem_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.pcFromMem |=> pc == $past(memRdData));

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = 16'h0100,
  parameter logic [ADDR_W-1:0] STACK_TOP  = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] target,
  input  logic              zeroFlag,
  input  logic              negFlag,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic              busy,
  output logic              stackUnderflow,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrData,
  output logic              memRdEn,
  input  logic [ADDR_W-1:0] memRdData
);

  seqStrobe_t strobe;
  logic       spAtTop;

  pcseq_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .zeroFlag  (zeroFlag),
    .negFlag   (negFlag),
    .spAtTop   (spAtTop),
    .strobe    (strobe),
    .busy      (busy),
    .underflow (stackUnderflow)
  );

  pcseq_dp #(
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR),
    .STACK_TOP  (STACK_TOP)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .target    (target),
    .memRdData (memRdData),
    .pc        (pc),
    .sp        (sp),
    .spAtTop   (spAtTop),
    .memAddr   (memAddr),
    .memWrData (memWrData)
  );

  assign memWrEn = strobe.memWr;
  assign memRdEn = strobe.memRd;

  // R10: a refused return holds the program counter and stack pointer
  p_uf_hold_r10: assert property (@(posedge clk) disable iff (rst)
    stackUnderflow |-> $stable(pc) && $stable(sp));

  // R7: the push happens only in the busy cycle
  p_wr_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> busy);

  // R8 / R10: a read starts only from idle and never on an empty stack
  p_rd_legal_r8: assert property (@(posedge clk) disable iff (rst)
    memRdEn |-> !busy && (sp != STACK_TOP));

endmodule

// File: tb/pc_sequencer_tb_top.sv
`timescale 1ns/1ps
module pc_sequencer_tb_top;

  localparam int          AW    = 16;
  localparam logic [15:0] START = 16'h0100;
  localparam logic [15:0] STOP  = 16'hFFF0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op = 4'd0;
  logic [AW-1:0] target = '0;
  logic          zeroFlag = 1'b0;
  logic          negFlag = 1'b0;
  logic [AW-1:0] pc, sp, memAddr, memWrData;
  logic [AW-1:0] memRdData = '0;
  logic          busy, stackUnderflow, memWrEn, memRdEn;

  always #5 clk = ~clk;

  pc_sequencer dut_i (
    .clk(clk), .rst(rst), .op(op), .target(target),
    .zeroFlag(zeroFlag), .negFlag(negFlag),
    .pc(pc), .sp(sp), .busy(busy), .stackUnderflow(stackUnderflow),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdEn(memRdEn), .memRdData(memRdData)
  );

  // stack memory environment
  logic [AW-1:0] mem [0:255];
  always @(posedge clk) begin
    if (memWrEn) mem[memAddr[7:0]] <= memWrData;
    if (memRdEn) memRdData <= mem[memAddr[7:0]];
  end

  typedef struct {
    logic [AW-1:0] pc;
    logic [AW-1:0] sp;
    logic          busy;
    logic          uf;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 1'b0;

  // reference model state
  logic [AW-1:0] mPc = START;
  logic [AW-1:0] mSp = STOP;
  logic          mBusy = 1'b0;
  logic          mPendCall = 1'b0;
  logic [AW-1:0] mTarget = '0;
  logic [AW-1:0] retQ[$];

  task automatic compare(input exp_t e);
    nChecks++;
    if (pc !== e.pc || sp !== e.sp || busy !== e.busy || stackUnderflow !== e.uf) begin
      nFails++;
      $display("FAIL %s: pc=%h sp=%h busy=%b uf=%b expected pc=%h sp=%h busy=%b uf=%b",
               e.tag, pc, sp, busy, stackUnderflow, e.pc, e.sp, e.busy, e.uf);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  task automatic step(input logic [3:0] o, input logic [AW-1:0] t,
                      input logic z, input logic n, input string tag);
    exp_t e;
    logic uf = 1'b0;
    op = o; target = t; zeroFlag = z; negFlag = n;
    if (mBusy) begin
      if (mPendCall) mPc = mTarget;
      else begin mPc = retQ.pop_front(); mSp = mSp + 1; end
      mBusy = 1'b0;
    end else begin
      case (o)
        4'd1: mPc = t;
        4'd2: mPc = z ? t : mPc + 1;
        4'd3: mPc = (!z && !n) ? t : mPc + 1;
        4'd4: mPc = n ? t : mPc + 1;
        4'd5: mPc = mPc + 2;
        4'd6: mPc = z ? mPc + 2 : mPc + 1;
        4'd7: begin
          retQ.push_front(mPc + 1);
          mSp = mSp - 1; mTarget = t; mPendCall = 1'b1; mBusy = 1'b1;
        end
        4'd8: begin
          if (mSp == STOP) uf = 1'b1;
          else begin mPendCall = 1'b0; mBusy = 1'b1; end
        end
        default: mPc = mPc + 1;
      endcase
    end
    e.pc = mPc; e.sp = mSp; e.busy = mBusy; e.uf = uf; e.tag = tag;
    expQ.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.pc = START; r.sp = STOP; r.busy = 1'b0; r.uf = 1'b0; r.tag = "R1 in reset";
    compare(r);
    rst = 1'b0;
    r.tag = "R1 after reset";
    compare(r);

    step(4'd0,  16'h0000, 0, 0, "R2 advance");
    step(4'd12, 16'h7777, 1, 1, "R2 unused code");
    step(4'd1,  16'h0200, 0, 0, "R3 jump");
    step(4'd2,  16'h0300, 1, 0, "R4 bz taken");
    step(4'd2,  16'h0999, 0, 1, "R4 bz not taken");
    step(4'd3,  16'h0400, 0, 0, "R5 bp taken");
    step(4'd3,  16'h0999, 0, 1, "R5 bp not taken neg");
    step(4'd3,  16'h0999, 1, 0, "R5 bp not taken zero");
    step(4'd4,  16'h0500, 0, 1, "R5 bn taken");
    step(4'd4,  16'h0999, 0, 0, "R5 bn not taken");
    step(4'd5,  16'h0999, 0, 0, "R6 skip");
    step(4'd6,  16'h0999, 1, 0, "R6 skz taken");
    step(4'd6,  16'h0999, 0, 0, "R6 skz not taken");
    step(4'd8,  16'h0999, 0, 0, "R10 return empty");
    step(4'd0,  16'h0000, 0, 0, "R10 pulse ends");
    step(4'd7,  16'h1000, 0, 0, "R7 call first");
    step(4'd1,  16'h2222, 1, 1, "R9 jump ignored while busy");
    step(4'd0,  16'h0000, 0, 0, "R2 in subroutine");
    step(4'd7,  16'h2000, 0, 0, "R7 nested call");
    step(4'd8,  16'h3333, 0, 0, "R9 return ignored while busy");
    step(4'd5,  16'h0000, 0, 0, "R6 skip in nested");
    step(4'd8,  16'h0000, 0, 0, "R8 return inner");
    step(4'd7,  16'h4444, 0, 0, "R9 call ignored while busy");
    step(4'd8,  16'h0000, 0, 0, "R8 return outer");
    step(4'd0,  16'h0000, 0, 0, "R8 return outer done");
    step(4'd8,  16'h0000, 0, 0, "R10 empty again");
    step(4'd0,  16'h0000, 0, 0, "R2 final advance");
    @(posedge clk); #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule